// File: doc/BRIEF.md
# Serial-Controlled Wiper Position Register

This block is the digital side of a one- or two-channel digital potentiometer. It is an SPI slave in mode 0. It takes 16-bit command frames, most significant bit first, while chip select is held low. Each frame either writes or reads the position register of one wiper. The stored positions appear on a parallel output bus, which would drive the tap selection of a resistor ladder.

The first byte of a frame holds three fields. Bits [7:4] are the register address and bits [3:2] are the command code. Bits [1:0] carry the top two bits of a 10-bit data word, and the second byte carries its low eight bits. While the first byte is shifting in, the slave shifts out a flag saying whether the address and command form a legal pair. On a read, the slave returns the position in the rest of the frame. The whole block runs on a system clock and oversamples SCK, chip select and MOSI through two-flop synchronizers, so SCK must be slow compared with that clock.

Top module: `potWiperSpi`

## Requirements
- R1: After reset every wiper holds mid-scale, FULL_SCALE/2, and MISO is 1.
- R2: A 16-bit frame with command 00 to an address below NUM_WIPERS loads that wiper with the 10-bit data {byte0[1:0], byte1}. The new value appears on wiperPos at the third clk rising edge after csN rises, and not before.
- R3: A write value above FULL_SCALE is stored as FULL_SCALE.
- R4: An address at or above NUM_WIPERS, or command code 01 or 10, leaves every wiper unchanged. For such a frame the returned first byte has bit 1 = 0.
- R5: For a legal pair (command 00 or 11, address below NUM_WIPERS), returned first-byte bit 1 is 1. Returned first-byte bits [7:2] are always 1.
- R6: On a legal read, returned first-byte bit 0 is bit 8 of the position and the second byte is bits [7:0] of the position. A full-scale position of 256 therefore returns 0xFF then 0x00. On every other frame, returned bit 0 is 0 and the second byte is 0xFF.
- R7: A frame that does not hold exactly 16 SCK rising edges when csN rises is discarded, and all wipers stay unchanged.
- R8: MOSI is sampled on SCK rising edges. MISO changes only after SCK falling edges and is 1 while csN is high.
- R9: Wiper i occupies wiperPos[i*POS_W +: POS_W], where POS_W = clog2(FULL_SCALE+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |
| wiperPos | output | NUM_WIPERS*POS_W | Wiper positions, packed |

## Verification
Each SCK or csN edge passes through two synchronizer flops and then one output register. MISO therefore settles three clk edges after an SCK fall, and a write lands on wiperPos at the third clk edge after csN rises. The bench holds each SCK phase for eight clk cycles and reads MISO just before it raises SCK. For one write, it checks that wiperPos is unchanged after two edges and updated after three. Every other frame is checked a few cycles after csN rises, once the update latency has passed.

// File: rtl/potSpiPkg.sv
package potSpiPkg;
  localparam int FRAME_BITS = 16;
  localparam logic [1:0] CMD_WR = 2'b00;
  localparam logic [1:0] CMD_RD = 2'b11;

  typedef struct packed {
    logic        fallStb;
    logic        csIdle;
    logic        frameDone;
    logic [4:0]  bitIdx;
    logic [3:0]  hdrAddr;
    logic [1:0]  hdrCmd;
    logic [15:0] frame;
  } ctlStrobes_t;
endpackage

// File: rtl/potSpiCtrl.sv
module potSpiCtrl
  import potSpiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sck,
  input  logic        csN,
  input  logic        mosi,
  output ctlStrobes_t ctl
);
  logic [1:0]  sckSy, csSy, mosiSy;
  logic        sckPrev, csPrev;
  logic [4:0]  bitCnt;
  logic [15:0] shreg;
  logic [3:0]  hdrAddr;
  logic [1:0]  hdrCmd;
  logic        sckS, csS, mosiS, riseStb;

  assign sckS  = sckSy[1];
  assign csS   = csSy[1];
  assign mosiS = mosiSy[1];
  assign riseStb = sckS & ~sckPrev & ~csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSy <= '0; csSy <= '1; mosiSy <= '0;
      sckPrev <= 1'b0; csPrev <= 1'b1;
    end else begin
      sckSy  <= {sckSy[0], sck};
      csSy   <= {csSy[0], csN};
      mosiSy <= {mosiSy[0], mosi};
      sckPrev <= sckS;
      csPrev  <= csS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; shreg <= '0; hdrAddr <= '0; hdrCmd <= '0;
    end else begin
      if (csS) bitCnt <= '0;
      else if (riseStb && bitCnt != 5'd17) bitCnt <= bitCnt + 5'd1;
      if (riseStb) shreg <= {shreg[14:0], mosiS};
      if (riseStb && bitCnt == 5'd5) begin
        hdrAddr <= shreg[4:1];
        hdrCmd  <= {shreg[0], mosiS};
      end
    end
  end

  always_comb begin
    ctl.fallStb   = ~sckS & sckPrev & ~csS;
    ctl.csIdle    = csS;
    ctl.frameDone = csS & ~csPrev & (bitCnt == 5'(FRAME_BITS));
    ctl.bitIdx    = bitCnt;
    ctl.hdrAddr   = hdrAddr;
    ctl.hdrCmd    = hdrCmd;
    ctl.frame     = shreg;
  end

  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == 5'd0)); // R7
endmodule

// File: rtl/potSpiData.sv
module potSpiData
  import potSpiPkg::*;
#(
  parameter int NUM_WIPERS = 2,
  parameter int FULL_SCALE = 256,
  parameter int POS_W      = $clog2(FULL_SCALE + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctlStrobes_t                 ctl,
  output logic                        miso,
  output logic [NUM_WIPERS*POS_W-1:0] wiperPos
);
  localparam logic [3:0] NW4   = 4'(NUM_WIPERS);
  localparam logic [9:0] FULL10 = 10'(FULL_SCALE);
  localparam logic [POS_W-1:0] MID = POS_W'(FULL_SCALE / 2);

  logic [POS_W-1:0] wiperReg [NUM_WIPERS];
  logic             misoR;
  logic             hdrValid, isRead, writeOk;
  logic [8:0]       readExt;
  logic [3:0]       fAddr;
  logic [1:0]       fCmd;
  logic [9:0]       fData;
  logic [POS_W-1:0] clamped;
  logic [4:0]       revIdx;

  assign hdrValid = ((ctl.hdrCmd == CMD_WR) || (ctl.hdrCmd == CMD_RD)) && (ctl.hdrAddr < NW4);
  assign isRead   = hdrValid && (ctl.hdrCmd == CMD_RD);
  assign fAddr    = ctl.frame[15:12];
  assign fCmd     = ctl.frame[11:10];
  assign fData    = ctl.frame[9:0];
  assign writeOk  = ctl.frameDone && (fCmd == CMD_WR) && (fAddr < NW4);
  assign clamped  = (fData > FULL10) ? POS_W'(FULL_SCALE) : fData[POS_W-1:0];
  assign revIdx   = 5'd15 - ctl.bitIdx;

  always_comb begin
    readExt = '0;
    for (int i = 0; i < NUM_WIPERS; i++)
      if (ctl.hdrAddr == 4'(i)) readExt = 9'(wiperReg[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) misoR <= 1'b1;
    else if (ctl.csIdle) misoR <= 1'b1;
    else if (ctl.fallStb) begin
      if (ctl.bitIdx == 5'd6)      misoR <= hdrValid;
      else if (ctl.bitIdx == 5'd7) misoR <= isRead & readExt[8];
      else if (ctl.bitIdx >= 5'd8 && ctl.bitIdx <= 5'd15)
        misoR <= isRead ? readExt[revIdx[2:0]] : 1'b1;
      else misoR <= 1'b1;
    end
  end
  assign miso = misoR;

  AST_MISO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ctl.csIdle |=> misoR); // R8
  AST_FLAG_LOW_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fallStb && ctl.bitIdx == 5'd6 && !hdrValid) |=> !misoR); // R4

  for (genvar g = 0; g < NUM_WIPERS; g++) begin : gWiper
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wiperReg[g] <= MID;
      else if (writeOk && fAddr == 4'(g)) wiperReg[g] <= clamped;
    end
    assign wiperPos[g*POS_W +: POS_W] = wiperReg[g];

    AST_WIPER_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
      10'(wiperReg[g]) <= FULL10); // R3
    AST_HOLD_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
      !ctl.frameDone |=> $stable(wiperReg[g])); // R7
    AST_BAD_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.frameDone && !writeOk) |=> $stable(wiperReg[g])); // R4
  end
endmodule

// File: rtl/potWiperSpi.sv
module potWiperSpi
  import potSpiPkg::*;
#(
  parameter int NUM_WIPERS = 2,
  parameter int FULL_SCALE = 256,
  parameter int POS_W      = $clog2(FULL_SCALE + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sck,
  input  logic                        csN,
  input  logic                        mosi,
  output logic                        miso,
  output logic [NUM_WIPERS*POS_W-1:0] wiperPos
);
  ctlStrobes_t ctl;

  potSpiCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .ctl(ctl)
  );

  potSpiData #(.NUM_WIPERS(NUM_WIPERS), .FULL_SCALE(FULL_SCALE), .POS_W(POS_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .miso(miso), .wiperPos(wiperPos)
  );
endmodule

// File: tb/tb_potWiperSpi.sv
`timescale 1ns/1ps
module tb_potWiperSpi;
  localparam int NW = 2;
  localparam int FS = 256;
  localparam int PW = 9;
  localparam int HALF = 8;

  logic clk = 0, rstN = 0, sck = 0, csN = 1, mosi = 0;
  logic miso;
  logic [NW*PW-1:0] wiperPos;
  int checks = 0, errors = 0;
  int model [NW];
  logic [15:0] rx;

  always #2.5 clk = ~clk;

  potWiperSpi #(.NUM_WIPERS(NW), .FULL_SCALE(FS)) dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .miso(miso), .wiperPos(wiperPos)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shiftFrame(input logic [15:0] tx, input int nbits, output logic [15:0] r);
    r = '0;
    @(negedge clk); csN = 0;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[15-i];
      waitClk(HALF);
      if (i < 16) r[15-i] = miso;
      sck = 1;
      waitClk(HALF);
      sck = 0;
    end
    waitClk(HALF);
  endtask

  task automatic endFrame();
    @(negedge clk); csN = 1;
    waitClk(6);
  endtask

  task automatic checkWipers(string req);
    for (int i = 0; i < NW; i++)
      check(req, int'(wiperPos[i*PW +: PW]), model[i]);
  endtask

  function automatic logic [15:0] mk(int addr, int cmd, int data);
    return {4'(addr), 2'(cmd), 10'(data)};
  endfunction

  initial begin : watchdog
    waitClk(190000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitClk(4); rstN = 1; waitClk(4);
    for (int i = 0; i < NW; i++) model[i] = FS / 2;
    checkWipers("R1 reset mid-scale");
    check("R1/R8 miso idle", int'(miso), 1);

    // R2 latency: unchanged after two edges, updated after the third
    shiftFrame(mk(0, 0, 77), 16, rx);
    @(negedge clk); csN = 1;
    @(posedge clk); @(posedge clk); #1;
    check("R2 no early update", int'(wiperPos[0 +: PW]), model[0]);
    @(posedge clk); #1;
    model[0] = 77;
    check("R2 update at third edge", int'(wiperPos[0 +: PW]), 77);
    waitClk(6);

    // R2 R3 R5 R6 sweep over both wipers and the full data range
    for (int a = 0; a < NW; a++) begin
      for (int v = 0; v < 1024; v += 37) begin
        int vv, exp;
        vv = (v == 37) ? 256 : (v == 74) ? 255 : (v == 111) ? 257 : v;
        exp = (vv > FS) ? FS : vv;
        shiftFrame(mk(a, 0, vv), 16, rx); endFrame();
        model[a] = exp;
        checkWipers("R2/R3 write and clamp");
        check("R5 write flag byte", int'(rx), 16'hFEFF);
        shiftFrame(mk(a, 3, 0), 16, rx); endFrame();
        check("R6 read back", int'(rx), int'({7'h7F, 9'(exp)}));
        checkWipers("R6 read leaves wipers");
      end
    end
    // R6 explicit full scale: 0xFF then 0x00
    shiftFrame(mk(1, 0, 300), 16, rx); endFrame(); model[1] = FS;
    shiftFrame(mk(1, 3, 0), 16, rx); endFrame();
    check("R6 full-scale read", int'(rx), 16'hFF00);

    // R4 invalid addresses and commands
    for (int a = NW; a < 16; a++) begin
      shiftFrame(mk(a, 0, 5), 16, rx); endFrame();
      check("R4 bad address flag", int'(rx), 16'hFCFF);
      checkWipers("R4 bad address no change");
    end
    for (int c = 1; c < 3; c++) begin
      shiftFrame(mk(0, c, 9), 16, rx); endFrame();
      check("R4 bad command flag", int'(rx), 16'hFCFF);
      checkWipers("R4 bad command no change");
    end
    shiftFrame(mk(7, 3, 0), 16, rx); endFrame();
    check("R4 bad read flag", int'(rx), 16'hFCFF);

    // R7 short and long frames discarded
    shiftFrame(mk(0, 0, 3), 15, rx); endFrame();
    checkWipers("R7 short frame");
    shiftFrame(mk(1, 0, 4), 17, rx); endFrame();
    checkWipers("R7 long frame");
    shiftFrame(mk(0, 0, 2), 8, rx); endFrame();
    checkWipers("R7 one-byte frame");
    // R9 field placement after distinct writes
    shiftFrame(mk(0, 0, 1), 16, rx); endFrame(); model[0] = 1;
    shiftFrame(mk(1, 0, 170), 16, rx); endFrame(); model[1] = 170;
    check("R9 packing", int'(wiperPos), (170 << PW) | 1);
    check("R8 miso idle after frames", int'(miso), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule